// File: doc/BRIEF.md
# Reference-Domain Phase Accumulator and Frequency Detector

This block sits in the retimed reference clock domain of an all-digital PLL. On each reference edge, marked by a tick strobe, it updates a fixed-point reference phase and takes in a sampled count of oscillator cycles. It also takes the fractional timing error measured by a time-to-digital converter. From these it produces two results. The first is an acquisition error word, used by a binary-search controller to decide whether the oscillator tuning word must go up or down. The second is a phase error word, used once the loop runs closed.

Three modes change how the reference phase is updated.
- In the plain accumulate mode the frequency command word is added to the reference phase.
- With zero-phase restart, the reference phase is re-seeded from the previous variable phase. The acquisition error then reduces to a pure frequency difference: the command word minus the measured cycle count, corrected by the change in fractional error.
- A close-loop request removes the previous fractional error from the reference phase. This aligns the phase error with the acquisition error before tracking begins.

The oscillator, the time-to-digital converter and the clock retiming are outside the block.

Top module: `fdet_core`

## Requirements
- R1: While rst_n is low, and after its release, acq_err, phase_err and err_valid are all zero. The internal reference phase, previous variable phase and previous fractional error also start at zero.
- R2: Phases are unsigned fixed point, with 16 integer cycle bits above 10 fractional bits (26 bits) that wrap modulo 2^16 cycles. fcw carries integer bits [17:10] and fractional bits [9:0]. On a tick with close_req low and no restart, the reference phase becomes the previous reference phase plus fcw.
- R3: On a cycle with ref_tick low, no state changes, acq_err and phase_err hold their values, and err_valid is low on the next cycle.
- R4: On each tick, acq_err is computed modulo 2^26 and read as a two's complement value. It equals the new reference phase, minus var_cnt placed in the integer field, plus frac_err (weight 2^-10), minus the frac_err of the previous tick.
- R5: On a tick with acq_mode and zpr_en high and close_req low, the reference phase is loaded with the previous tick's variable phase plus fcw. acq_err then equals fcw minus the cycle count since the previous tick, plus the change in frac_err. It is positive when the oscillator ran slow.
- R6: On a tick with close_req high, the reference phase is loaded with its previous value plus fcw minus the previous tick's frac_err. This takes priority over zero-phase restart and applies in either mode.
- R7: On each tick, phase_err equals the new reference phase minus the variable phase plus the current frac_err, with no previous-sample term.
- R8: The previous-fractional-error register and the previous variable phase are updated on every tick, whatever the mode.
- R9: err_valid is high for exactly the one cycle after each tick. acq_err and phase_err carry the new values in that same cycle.
- R10: frac_err is non-zero on every tick, because the fractional error lies strictly between 0 and 1 of an oscillator period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Retimed reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Marks a reference edge on which all state advances |
| acq_mode | input | 1 | 1 = acquisition, 0 = closed loop |
| zpr_en | input | 1 | Zero-phase restart enable (acquisition only) |
| close_req | input | 1 | One-tick request to enter closed loop |
| fcw | input | 18 | Frequency command word, 8 integer and 10 fractional bits |
| var_cnt | input | 16 | Sampled oscillator cycle counter (wrapping) |
| frac_err | input | 10 | Fractional timing error, units of 2^-10 period |
| acq_err | output | 26 | Acquisition error, signed Q16.10 |
| phase_err | output | 26 | Closed-loop phase error, signed Q16.10 |
| err_valid | output | 1 | One-cycle strobe for a new error pair |

## Verification
The assertions rely on two properties of the inputs. First, frac_err is never zero on a tick, since the time-to-digital converter reports a strictly fractional delay. Second, the tick strobe alone gates every state change. The stimulus draws frac_err from the range 1 to 1023 only. It holds var_cnt in a running counter advanced by chosen deltas around the integer command word, and starts that counter near the 16-bit wrap point. It places idle cycles between ticks so that the hold behaviour is observed at the ports.

// File: rtl/fdet_pkg.sv
package fdet_pkg;

    // Source selected for the next reference phase value
    typedef enum logic [1:0] {
        REF_HOLD    = 2'd0,
        REF_ACCUM   = 2'd1,
        REF_RESTART = 2'd2,
        REF_CLOSE   = 2'd3
    } ref_sel_e;

endpackage

// File: rtl/fdet_sample.sv
module fdet_sample #(
    parameter int CNT_W  = 16,
    parameter int FRAC_W = 10,
    localparam int PW    = CNT_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CNT_W-1:0]  var_cnt,
    input  logic [FRAC_W-1:0] frac_err,
    output logic [PW-1:0]     var_prev,
    output logic [PW-1:0]     eps_prev
);

    typedef struct packed {
        logic [PW-1:0] var_ph;
        logic [PW-1:0] eps;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d = smp_q;
        if (tick) begin
            smp_d.var_ph = {var_cnt, {FRAC_W{1'b0}}};
            smp_d.eps    = PW'(frac_err);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    assign var_prev = smp_q.var_ph;
    assign eps_prev = smp_q.eps;

    // R3
    sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(var_prev) && $stable(eps_prev)));

endmodule

// File: rtl/fdet_ref_accum.sv
module fdet_ref_accum
    import fdet_pkg::*;
#(
    parameter int PW = 26
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ref_sel_e      sel,
    input  logic [PW-1:0] fcw_ext,
    input  logic [PW-1:0] var_prev,
    input  logic [PW-1:0] eps_prev,
    output logic [PW-1:0] ref_nxt
);

    logic [PW-1:0] ref_d, ref_q;

    always_comb begin
        unique case (sel)
            REF_ACCUM:   ref_d = ref_q + fcw_ext;
            REF_RESTART: ref_d = var_prev + fcw_ext;
            REF_CLOSE:   ref_d = ref_q + fcw_ext - eps_prev;
            default:     ref_d = ref_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ref_q <= '0;
        else        ref_q <= ref_d;
    end

    assign ref_nxt = ref_d;

    // R3
    ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == REF_HOLD) |=> $stable(ref_q));

endmodule

// File: rtl/fdet_core.sv
module fdet_core
    import fdet_pkg::*;
#(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 10,
    parameter int CNT_W  = 16,
    localparam int FCW_W = INT_W + FRAC_W,
    localparam int PW    = CNT_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              acq_mode,
    input  logic              zpr_en,
    input  logic              close_req,
    input  logic [FCW_W-1:0]  fcw,
    input  logic [CNT_W-1:0]  var_cnt,
    input  logic [FRAC_W-1:0] frac_err,
    output logic [PW-1:0]     acq_err,
    output logic [PW-1:0]     phase_err,
    output logic              err_valid
);

    typedef struct packed {
        logic [PW-1:0] acq;
        logic [PW-1:0] ph;
        logic          vld;
    } out_t;

    out_t          out_d, out_q;
    ref_sel_e      sel;
    logic [PW-1:0] fcw_ext, var_now, eps_now;
    logic [PW-1:0] var_prev, eps_prev, ref_nxt;
    logic [PW-1:0] diff;

    assign fcw_ext = PW'(fcw);
    assign var_now = {var_cnt, {FRAC_W{1'b0}}};
    assign eps_now = PW'(frac_err);

    // Close request outranks zero-phase restart
    always_comb begin
        if (!ref_tick)                sel = REF_HOLD;
        else if (close_req)           sel = REF_CLOSE;
        else if (acq_mode && zpr_en)  sel = REF_RESTART;
        else                          sel = REF_ACCUM;
    end

    fdet_sample #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) i_sample (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (ref_tick),
        .var_cnt  (var_cnt),
        .frac_err (frac_err),
        .var_prev (var_prev),
        .eps_prev (eps_prev)
    );

    fdet_ref_accum #(.PW(PW)) i_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .fcw_ext  (fcw_ext),
        .var_prev (var_prev),
        .eps_prev (eps_prev),
        .ref_nxt  (ref_nxt)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = ref_tick;
        diff      = ref_nxt - var_now + eps_now;
        if (ref_tick) begin
            out_d.ph  = diff;
            out_d.acq = diff - eps_prev;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign acq_err   = out_q.acq;
    assign phase_err = out_q.ph;
    assign err_valid = out_q.vld;

    // R10
    frac_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick |-> (frac_err != '0));

    // R3
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_tick |=> ($stable(acq_err) && $stable(phase_err) && !err_valid));

    // R8
    eps_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick |=> ((phase_err - acq_err) == $past(eps_prev)));

    // R9
    valid_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick |=> err_valid);

endmodule

// File: tb/test_fdet_core.sv
`timescale 1ns/1ps
module test_fdet_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0, acq_mode = 1'b0, zpr_en = 1'b0, close_req = 1'b0;
    logic [17:0] fcw = '0;
    logic [15:0] var_cnt = '0;
    logic [9:0]  frac_err = 10'd1;
    logic [25:0] acq_err, phase_err;
    logic        err_valid;

    int n_tests = 0, n_fail = 0;

    logic [25:0] m_ref = '0, m_varp = '0, m_epsp = '0;
    logic [15:0] v_cur = '0;

    always #2 clk = ~clk;

    fdet_core i_fdet_core (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .acq_mode(acq_mode),
        .zpr_en(zpr_en), .close_req(close_req), .fcw(fcw), .var_cnt(var_cnt),
        .frac_err(frac_err), .acq_err(acq_err), .phase_err(phase_err),
        .err_valid(err_valid)
    );

    task automatic chk(input logic [25:0] act, input logic [25:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input bit acq, input bit zpr, input bit cls,
                        input logic [17:0] f, input int delta,
                        input logic [9:0] e, input string tag);
        logic [25:0] vph, ea, ep;
        v_cur     = v_cur + 16'(delta);
        acq_mode  = acq; zpr_en = zpr; close_req = cls;
        fcw       = f;   var_cnt = v_cur; frac_err = e;
        ref_tick  = 1'b1;
        @(posedge clk); #1;
        ref_tick  = 1'b0; close_req = 1'b0;
        if (cls)            m_ref = m_ref + 26'(f) - m_epsp;
        else if (acq && zpr) m_ref = m_varp + 26'(f);
        else                m_ref = m_ref + 26'(f);
        vph = {v_cur, 10'b0};
        ep  = m_ref - vph + 26'(e);
        ea  = ep - m_epsp;
        m_varp = vph; m_epsp = 26'(e);
        chk(acq_err, ea, {tag, " acq_err"});
        chk(phase_err, ep, {tag, " phase_err"});
        chk(26'(err_valid), 26'd1, {tag, " R9 err_valid"});
    endtask

    task automatic idle(input string tag);
        logic [25:0] a0, p0;
        a0 = acq_err; p0 = phase_err;
        frac_err = 10'h3a5; var_cnt = 16'h1234; fcw = 18'h3ffff;
        @(posedge clk); #1;
        chk(acq_err, a0, {tag, " R3 acq hold"});
        chk(phase_err, p0, {tag, " R3 phase hold"});
        chk(26'(err_valid), 26'd0, {tag, " R3 R9 valid low"});
        var_cnt = v_cur;
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk(acq_err, 26'd0, "R1 acq_err reset");
        chk(phase_err, 26'd0, "R1 phase_err reset");
        chk(26'(err_valid), 26'd0, "R1 valid reset");
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(acq_err, 26'd0, "R1 acq_err after release");

        // R2, R7, R4: closed-loop accumulation, counter near wrap
        v_cur = 16'hffc0;
        for (int i = 0; i < 48; i++)
            step(1'b0, 1'b0, 1'b0, 18'h0a5a7, 10 + (i % 3), 10'(1 + (i * 37) % 1023), "R2 R7 accum");
        idle("R3 closed");

        // R4: acquisition without restart
        for (int i = 0; i < 24; i++)
            step(1'b1, 1'b0, 1'b0, 18'h05100, 5 - (i % 2), 10'(1 + (i * 91) % 1023), "R4 acq");

        // R5: zero-phase restart sweep
        for (int k = 0; k < 3; k++) begin
            logic [17:0] f;
            f = (k == 0) ? 18'h00c00 : (k == 1) ? 18'h02a80 : 18'h3fc00;
            for (int d = -3; d <= 3; d++) begin
                for (int j = 0; j < 4; j++) begin
                    logic [9:0] e;
                    int dl;
                    e  = (j == 0) ? 10'd1 : (j == 1) ? 10'd256 : (j == 2) ? 10'd512 : 10'd1023;
                    dl = int'(f[17:10]) + d;
                    step(1'b1, 1'b1, 1'b0, f, dl, e, "R5 zpr");
                    // same fractional error twice in a row -> sign test
                    step(1'b1, 1'b1, 1'b0, f, dl, e, "R5 zpr repeat");
                    n_tests++;
                    if (d < 0 && !(acq_err[25] == 1'b0 && acq_err != 0)) begin
                        n_fail++;
                        $display("FAIL R5 slow sign actual=%h expected=positive", acq_err);
                    end else if (d > 0 && acq_err[25] != 1'b1) begin
                        n_fail++;
                        $display("FAIL R5 fast sign actual=%h expected=negative", acq_err);
                    end
                    if (j == 2) idle("R3 zpr");
                end
            end
        end

        // R6: close-loop transition, with priority over restart
        for (int i = 0; i < 8; i++) begin
            step(1'b1, 1'b1, 1'b0, 18'h04080, 4, 10'(100 + i * 97), "R6 pre");
            step(1'b1, (i % 2) == 1, 1'b1, 18'h04080, 4, 10'(7 + i * 111), "R6 close");
            step(1'b0, 1'b0, 1'b0, 18'h04080, 4, 10'(900 - i * 50), "R6 R7 after");
        end

        // R8: previous fractional error tracked across mode changes
        for (int i = 0; i < 12; i++)
            step(i % 2 == 0, i % 3 == 0, 1'b0, 18'h01234, 4, 10'(1 + i * 83), "R8 modes");

        // R1: reset mid-run clears state
        rst_n = 1'b0; #1;
        chk(acq_err, 26'd0, "R1 async reset");
        @(posedge clk); #1;
        rst_n = 1'b1;
        m_ref = '0; m_varp = '0; m_epsp = '0; v_cur = '0;
        step(1'b1, 1'b1, 1'b0, 18'h00800, 2, 10'd300, "R1 R5 after reset");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule